// File: doc/BRIEF.md
# Fractional-Rate Real-Time Counter

This block keeps a free-running count that advances at a fixed nominal rate no matter which reference clock drives it. On every clock a programmable step value is added to a fractional remainder. Whenever that remainder reaches a programmable modulus, the count goes up by one and the modulus is taken back off the remainder. The average count rate is therefore the clock rate times step divided by modulus. For example, with a 6.144 MHz target, a 38.4 MHz reference uses 4/25, a 19.2 MHz reference uses 8/25, and a 20 MHz reference uses 192/625.

Software programs the two ratio terms through a small register port. Each register is 32 bits wide. Its low 12 bits hold the value, and its upper bits are kept so that read-modify-write sequences preserve them. The count has no stop, load or clear control. Only reset and the natural wrap of its width act on it.

Top module: `frac_rate_counter`

## Requirements
- R1: After a synchronous reset, the count is zero and the read data is zero. The step register reads NUM_RST (default 4) and the modulus register reads DEN_RST (default 25).
- R2: On every clock without a register write, the remainder gains the step value (bits 11:0 of the step register). If the sum is at least the modulus (bits 11:0 of the modulus register), the count increments by one in that cycle and the modulus is subtracted. Otherwise the sum is kept.
- R3: The count never advances by more than one per clock. When the step is at least the modulus, the count advances on every clock and the remainder is clamped to at most modulus minus one.
- R4: While the modulus value is zero, both the count and the remainder hold.
- R5: The step register is at byte address 0x10 and the modulus register at 0x14. A write to either one clears the remainder and holds the count in that cycle. The new value is used from the following cycle.
- R6: Bits 31:12 of both registers are stored and read back unchanged. They have no effect on counting.
- R7: A read strobe returns the addressed register on the read data port one cycle later, sampled before any write in the same cycle. Any other address reads zero. Without a strobe, the read data holds.
- R8: The count wraps from all ones to zero, modulo 2^CNT_W.
- R9: A write to any address other than 0x10 or 0x14 changes no register and does not disturb the remainder or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rt_count | output | CNT_W | Free-running count |

## Verification
The bench builds the block with CNT_W set to 16 and keeps the other parameters at their defaults. This makes the wrap of the count reachable in about 65 thousand clocks, using a one-to-one ratio. The 12-bit ratio fields and 32-bit registers stay at full size, so ratios up to 192/625, step-greater-than-modulus clamping, a zero modulus and preserved upper bits are all exercised at their real widths. A behavioural model in the bench predicts the count and the read data on every clock.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int REG_STEP = 0;
  localparam int REG_MOD  = 1;
  localparam int REG_N    = 2;
endpackage

// File: rtl/frc_regs.sv
module frc_regs
  import frc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int FRAC_W = 12,
  parameter int STEP_OFS = 'h10,
  parameter int MOD_OFS  = 'h14,
  parameter int NUM_RST = 4,
  parameter int DEN_RST = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [FRAC_W-1:0] step_fld,
  output logic [FRAC_W-1:0] mod_fld,
  output logic              wr_hit
);
  logic [DATA_W-1:0] regs_q [REG_N];
  logic [REG_N-1:0]  match;
  logic [DATA_W-1:0] rd_mux;

  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] OFS  = (i == REG_STEP) ? ADDR_W'(STEP_OFS) : ADDR_W'(MOD_OFS);
    localparam logic [DATA_W-1:0] RSTV = (i == REG_STEP) ? DATA_W'(NUM_RST) : DATA_W'(DEN_RST);
    assign match[i] = (addr == OFS);
    always_ff @(posedge clk) begin
      if (rst) regs_q[i] <= RSTV;
      else if (wr_en && match[i]) regs_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < REG_N; i++)
      if (match[i]) rd_mux = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign wr_hit   = wr_en && (|match);
  assign step_fld = regs_q[REG_STEP][FRAC_W-1:0];
  assign mod_fld  = regs_q[REG_MOD][FRAC_W-1:0];

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && match == '0) |=> rdata == '0);
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/frc_accum.sv
module frc_accum #(
  parameter int FRAC_W = 12,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] step,
  input  logic [FRAC_W-1:0] modulus,
  input  logic              clr,
  output logic [CNT_W-1:0]  count
);
  localparam int ACC_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc;
  logic [ACC_W-1:0]  sum, rem;
  logic              reach, clamp;

  assign sum   = {1'b0, acc} + {1'b0, step};
  assign reach = sum >= {1'b0, modulus};
  assign rem   = sum - {1'b0, modulus};
  assign clamp = rem >= {1'b0, modulus};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      count <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (modulus != '0) begin
      if (reach) begin
        count <= count + 1'b1;
        acc   <= clamp ? modulus - 1'b1 : rem[FRAC_W-1:0];
      end else begin
        acc <= sum[FRAC_W-1:0];
      end
    end
  end

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));
  assert_acc_below_mod_R3: assert property (@(posedge clk) disable iff (rst)
    (modulus != '0 && !clr) |=> acc < $past(modulus));
  assert_zero_mod_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (modulus == '0) |=> (count == $past(count) && acc == $past(acc)));
  assert_write_clears_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0 && count == $past(count)));
endmodule

// File: rtl/frac_rate_counter.sv
module frac_rate_counter #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int FRAC_W   = 12,
  parameter int CNT_W    = 64,
  parameter int STEP_OFS = 'h10,
  parameter int MOD_OFS  = 'h14,
  parameter int NUM_RST  = 4,
  parameter int DEN_RST  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  rt_count
);
  logic [FRAC_W-1:0] step_fld, mod_fld;
  logic              wr_hit;

  frc_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W),
    .STEP_OFS(STEP_OFS), .MOD_OFS(MOD_OFS),
    .NUM_RST(NUM_RST), .DEN_RST(DEN_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .step_fld(step_fld), .mod_fld(mod_fld), .wr_hit(wr_hit)
  );

  frc_accum #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst(rst), .step(step_fld), .modulus(mod_fld),
    .clr(wr_hit), .count(rt_count)
  );

  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !wr_hit) |=> ($stable(step_fld) && $stable(mod_fld)));
endmodule

// File: tb/frac_rate_counter_bench.sv
module frac_rate_counter_bench;
  localparam int CW = 16;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [CW-1:0] rt_count;

  frac_rate_counter #(.CNT_W(CW)) u_frac_rate_counter (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rt_count(rt_count)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural model
  longint m_num, m_den, m_acc, m_cnt, m_rdata, n, d, s;
  always @(posedge clk) begin
    if (rst) begin
      m_num = 4; m_den = 25; m_acc = 0; m_cnt = 0; m_rdata = 0;
    end else begin
      n = m_num & 'hFFF;
      d = m_den & 'hFFF;
      if (bus_rd)
        m_rdata = (bus_addr == 8'h10) ? m_num : (bus_addr == 8'h14) ? m_den : 0;
      if (bus_wr && (bus_addr == 8'h10 || bus_addr == 8'h14)) m_acc = 0;
      else if (d != 0) begin
        s = m_acc + n;
        if (s >= d) begin
          m_cnt = (m_cnt + 1) % (longint'(1) << CW);
          s = s - d;
          if (s >= d) s = d - 1;
        end
        m_acc = s;
      end
      if (bus_wr && bus_addr == 8'h10) m_num = longint'(bus_wdata);
      if (bus_wr && bus_addr == 8'h14) m_den = longint'(bus_wdata);
    end
  end

  task automatic check(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    check(phase, longint'(rt_count), m_cnt, "count");
    check(phase, longint'(bus_rdata), m_rdata, "rdata");
  end

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  logic [CW-1:0] prev;
  bit wrapped = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", longint'(rt_count), 0, "count after reset");
    check("R1", longint'(bus_rdata), 0, "rdata after reset");
    rd(8'h10); check("R1", longint'(bus_rdata), 4, "step reset");
    rd(8'h14); check("R1", longint'(bus_rdata), 25, "modulus reset");
    phase = "R2"; idle(500);
    phase = "R5"; wr(8'h10, 32'h000000C0); wr(8'h14, 32'h00000271);
    phase = "R2"; idle(2000);
    phase = "R6"; wr(8'h14, 32'hABCDE271); rd(8'h14);
    check("R6", longint'(bus_rdata), 'hABCDE271, "upper bits readback");
    wr(8'h10, 32'h55555008); wr(8'h14, 32'hFFFFF019);
    idle(600);
    phase = "R3"; wr(8'h10, 32'd30); idle(200);
    wr(8'h10, 32'hFFF); idle(100);
    phase = "R4"; wr(8'h14, 32'hFFFFF000); idle(100);
    phase = "R9"; wr(8'h14, 32'd7); wr(8'h10, 32'd3); idle(5);
    wr(8'h18, 32'd1); wr(8'h00, 32'd5); idle(20);
    rd(8'h10); check("R9", longint'(bus_rdata), 3, "step untouched");
    phase = "R7"; rd(8'h18); check("R7", longint'(bus_rdata), 0, "unmapped read");
    idle(3); check("R7", longint'(bus_rdata), 0, "rdata hold");
    phase = "R8"; wr(8'h10, 32'd1); wr(8'h14, 32'd1);
    prev = rt_count;
    for (int k = 0; k < 66000; k++) begin
      @(negedge clk);
      if (prev == '1 && rt_count == '0) wrapped = 1;
      prev = rt_count;
    end
    checks++;
    if (!wrapped) begin
      errors++;
      $display("FAIL R8 wrap actual=0 expected=1");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule